// File: doc/BRIEF.md
# Dual-Issue Shared Bus Writer

This block sits between two instruction slots that issue in the same cycle and a 16-bit bus shared by the units of a cluster. Each slot can ask to place either one byte or a full 16-bit word on the bus. The byte lanes belong to fixed slots. A byte from slot 1, the lower half of a schedule row, always travels on bus bits 7:0. A byte from slot 2, the upper half, always travels on bus bits 15:8. As a result, two byte writes can share the bus in one cycle.

A word write occupies the whole bus, so it excludes any write from the other slot. When that clash happens, slot 1 is served and slot 2 is discarded. A one-cycle conflict flag reports the clash.

The bus data, the per-lane valid strobes and the conflict flag are all registered. The result of a request appears on the cycle after it is presented and lasts for exactly one cycle. Any lane that no slot drives reads as zero, and its valid strobe stays low.

Top module: `dual_slot_bus_writer`

## Requirements
- R1: While reset is held and on the first cycle after it, busData, laneValid and conflict are all zero.
- R2: A byte request from slot 1 alone (slot1Req=1, slot1Wide=0) puts slot1Data[7:0] on busData[7:0] with laneValid=2'b01 and busData[15:8]=0, one cycle after the request.
- R3: A byte request from slot 2 alone puts slot2Data[7:0] on busData[15:8] with laneValid=2'b10 and busData[7:0]=0, one cycle later.
- R4: Byte requests from both slots in the same cycle produce busData={slot2Data[7:0], slot1Data[7:0]}, laneValid=2'b11 and conflict=0 one cycle later.
- R5: A word request (Wide=1) from one slot while the other slot is idle puts that slot's full 16-bit data on the bus with laneValid=2'b11 and conflict=0 one cycle later.
- R6: A word request from slot 1 together with any request from slot 2 puts slot1Data on the bus with laneValid=2'b11 and conflict=1. Slot 2's data does not appear.
- R7: A byte request from slot 1 together with a word request from slot 2 gives busData={8'h00, slot1Data[7:0]}, laneValid=2'b01 and conflict=1.
- R8: A lane whose valid strobe is low reads zero. With no request, all outputs are zero on the next cycle.
- R9: Each result is held for one cycle only. An idle cycle after a request returns every output to zero.
- R10: The Wide and Data inputs of a slot whose Req is low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slot1Req | input | 1 | Slot 1 requests a bus write |
| slot1Wide | input | 1 | Slot 1 write is 16-bit (1) or 8-bit (0) |
| slot1Data | input | 16 | Slot 1 write data; bits 7:0 used for byte writes |
| slot2Req | input | 1 | Slot 2 requests a bus write |
| slot2Wide | input | 1 | Slot 2 write is 16-bit (1) or 8-bit (0) |
| slot2Data | input | 16 | Slot 2 write data; bits 7:0 used for byte writes |
| busData | output | 16 | Registered bus data |
| laneValid | output | 2 | Bit 0: low lane carries data; bit 1: high lane carries data |
| conflict | output | 1 | A word write clashed with the other slot last cycle |

## Verification
The assertions assume that the request, width and data inputs are settled at each rising edge and change only between edges, because each property compares the outputs with the inputs sampled one edge earlier. The stimulus meets this by applying every request on the falling edge. Garbage values go on the Wide and Data inputs of idle slots, so any leak from a slot that is not requesting shows up at the bus. The sequence covers every pairing of idle, byte and word requests across the two slots, including back-to-back requests and idle cycles between them.

// File: rtl/busw_pkg.sv
package busw_pkg;

  // Strobes from the arbitration control to the lane datapath.
  typedef struct packed {
    logic wide1;    // slot 1 owns the whole bus
    logic wide2;    // slot 2 owns the whole bus
    logic narrow1;  // slot 1 byte on the low lane
    logic narrow2;  // slot 2 byte on the high lane
    logic clash;    // a word write met another request
  } buswStrobe_t;

endpackage

// File: rtl/busw_ctrl.sv
module busw_ctrl
  import busw_pkg::*;
(
  input  logic        slot1Req,
  input  logic        slot1Wide,
  input  logic        slot2Req,
  input  logic        slot2Wide,
  output buswStrobe_t strobe
);

  logic want1Wide;
  logic want1Byte;
  logic want2Wide;
  logic want2Byte;

  always_comb begin
    want1Wide = slot1Req && slot1Wide;
    want1Byte = slot1Req && !slot1Wide;
    want2Wide = slot2Req && slot2Wide;
    want2Byte = slot2Req && !slot2Wide;

    // Slot 1 always keeps its grant; slot 2 yields whenever a word write is involved.
    strobe.wide1   = want1Wide;
    strobe.narrow1 = want1Byte;
    strobe.wide2   = want2Wide && !slot1Req;
    strobe.narrow2 = want2Byte && !want1Wide;
    strobe.clash   = (want1Wide && slot2Req) || (want2Wide && slot1Req);
  end

  // At most one slot may own the whole bus.
  always_comb begin
    AST_ONE_WIDE_OWNER: assert (!(strobe.wide1 && strobe.wide2)); // R6
  end

endmodule

// File: rtl/busw_dpath.sv
module busw_dpath
  import busw_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int LANES = 2,
  localparam int BUS_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  buswStrobe_t       strobe,
  input  logic [BUS_W-1:0]  slot1Data,
  input  logic [BUS_W-1:0]  slot2Data,
  output logic [BUS_W-1:0]  busData,
  output logic [LANES-1:0]  laneValid,
  output logic              conflict
);

  logic [BUS_W-1:0] busNext;
  logic [LANES-1:0] validNext;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    // Each lane has one byte owner: slot 1 for lane 0, slot 2 for lane 1.
    logic ownerByte;
    logic [LANE_W-1:0] ownerData;
    if (g == 0) begin : gLow
      assign ownerByte = strobe.narrow1;
      assign ownerData = slot1Data[LANE_W-1:0];
    end else begin : gHigh
      assign ownerByte = strobe.narrow2;
      assign ownerData = slot2Data[LANE_W-1:0];
    end

    always_comb begin
      if (strobe.wide1) begin
        busNext[g*LANE_W +: LANE_W] = slot1Data[g*LANE_W +: LANE_W];
        validNext[g] = 1'b1;
      end else if (strobe.wide2) begin
        busNext[g*LANE_W +: LANE_W] = slot2Data[g*LANE_W +: LANE_W];
        validNext[g] = 1'b1;
      end else if (ownerByte) begin
        busNext[g*LANE_W +: LANE_W] = ownerData;
        validNext[g] = 1'b1;
      end else begin
        busNext[g*LANE_W +: LANE_W] = '0;
        validNext[g] = 1'b0;
      end
    end

    AST_LANE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      !laneValid[g] |-> busData[g*LANE_W +: LANE_W] == '0); // R8
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busData   <= '0;
      laneValid <= '0;
      conflict  <= 1'b0;
    end else begin
      busData   <= busNext;
      laneValid <= validNext;
      conflict  <= strobe.clash;
    end
  end

endmodule

// File: rtl/dual_slot_bus_writer.sv
module dual_slot_bus_writer
  import busw_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int BUS_W = 2 * LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slot1Req,
  input  logic             slot1Wide,
  input  logic [BUS_W-1:0] slot1Data,
  input  logic             slot2Req,
  input  logic             slot2Wide,
  input  logic [BUS_W-1:0] slot2Data,
  output logic [BUS_W-1:0] busData,
  output logic [1:0]       laneValid,
  output logic             conflict
);

  buswStrobe_t strobe;

  busw_ctrl u_ctrl (
    .slot1Req (slot1Req),
    .slot1Wide(slot1Wide),
    .slot2Req (slot2Req),
    .slot2Wide(slot2Wide),
    .strobe   (strobe)
  );

  busw_dpath #(.LANE_W(LANE_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .slot1Data(slot1Data),
    .slot2Data(slot2Data),
    .busData  (busData),
    .laneValid(laneValid),
    .conflict (conflict)
  );

  AST_PAIR_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    (slot1Req && !slot1Wide && slot2Req && !slot2Wide) |=>
      (laneValid == 2'b11 && !conflict)); // R4

  AST_WIDE1_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (slot1Req && slot1Wide) |=>
      (busData == $past(slot1Data) && laneValid == 2'b11)); // R6

  AST_CONFLICT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    conflict |-> ($past(slot1Req) && $past(slot2Req)
                  && ($past(slot1Wide) || $past(slot2Wide)))); // R7

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (!slot1Req && !slot2Req) |=>
      (busData == '0 && laneValid == 2'b00 && !conflict)); // R9

endmodule

// File: tb/dual_slot_bus_writer_tb.sv
`timescale 1ns/1ps
module dual_slot_bus_writer_tb;

  typedef struct {
    logic [15:0] data;
    logic [1:0]  valid;
    logic        clash;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slot1Req = 1'b0, slot1Wide = 1'b0;
  logic        slot2Req = 1'b0, slot2Wide = 1'b0;
  logic [15:0] slot1Data = '0, slot2Data = '0;
  logic [15:0] busData;
  logic [1:0]  laneValid;
  logic        conflict;

  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_slot_bus_writer u_dut (
    .clk(clk), .rstN(rstN),
    .slot1Req(slot1Req), .slot1Wide(slot1Wide), .slot1Data(slot1Data),
    .slot2Req(slot2Req), .slot2Wide(slot2Wide), .slot2Data(slot2Data),
    .busData(busData), .laneValid(laneValid), .conflict(conflict)
  );

  task automatic compare(expItem_t e);
    checks++;
    if (busData !== e.data || laneValid !== e.valid || conflict !== e.clash) begin
      errors++;
      $display("FAIL %s: got data=%h valid=%b conflict=%b, expected data=%h valid=%b conflict=%b",
               e.tag, busData, laneValid, conflict, e.data, e.valid, e.clash);
    end
  endtask

  // Driver: applies one request pair on a falling edge and queues the expected result.
  task automatic drive(input logic r1, input logic w1, input logic [15:0] d1,
                       input logic r2, input logic w2, input logic [15:0] d2,
                       input string tag);
    expItem_t e;
    @(negedge clk);
    slot1Req = r1; slot1Wide = w1; slot1Data = d1;
    slot2Req = r2; slot2Wide = w2; slot2Data = d2;
    e.data = 16'h0000; e.valid = 2'b00; e.clash = 1'b0; e.tag = tag;
    if (r1 && w1) begin
      e.data = d1; e.valid = 2'b11; e.clash = r2;
    end else if (r2 && w2 && !r1) begin
      e.data = d2; e.valid = 2'b11;
    end else begin
      if (r1) begin e.data[7:0] = d1[7:0]; e.valid[0] = 1'b1; end
      if (r2 && !w2) begin e.data[15:8] = d2[7:0]; e.valid[1] = 1'b1; end
      if (r1 && r2 && w2) e.clash = 1'b1;
    end
    expQ.push_back(e);
  endtask

  // Monitor: one cycle after each queued request, compare the registered outputs.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) compare(expQ.pop_front());
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    expItem_t z;
    z.data = 16'h0000; z.valid = 2'b00; z.clash = 1'b0;
    slot1Req = 1'b1; slot1Wide = 1'b1; slot1Data = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    z.tag = "R1 in reset";
    compare(z);
    slot1Req = 1'b0; slot1Wide = 1'b0; slot1Data = '0;
    rstN = 1'b1;
    @(negedge clk);
    z.tag = "R1 after reset";
    compare(z);

    drive(1, 0, 16'hAB12, 0, 1, 16'hDEAD, "R2 slot1 byte, R10 idle slot2");
    drive(0, 1, 16'hBEEF, 1, 0, 16'h5534, "R3 slot2 byte, R10 idle slot1");
    drive(1, 0, 16'h77A5, 1, 0, 16'h995A, "R4 two bytes");
    drive(1, 1, 16'hC3D2, 0, 0, 16'h1111, "R5 slot1 word");
    drive(0, 0, 16'h2222, 1, 1, 16'h8E4F, "R5 slot2 word");
    drive(1, 1, 16'h1357, 1, 0, 16'h2468, "R6 word1 vs byte2");
    drive(1, 1, 16'hA0B0, 1, 1, 16'hC0D0, "R6 word1 vs word2");
    drive(1, 0, 16'hF00D, 1, 1, 16'hCAFE, "R7 byte1 vs word2");
    drive(0, 1, 16'hFFFF, 0, 1, 16'hFFFF, "R8 R10 no request");
    drive(1, 0, 16'h0042, 1, 0, 16'h0000, "R8 zero data byte pair");
    drive(0, 0, 16'h0000, 0, 0, 16'h0000, "R9 idle after request");
    drive(0, 0, 16'h5A5A, 1, 1, 16'h6B6B, "R5 word2 back to back");
    drive(1, 0, 16'h00C1, 0, 0, 16'h0000, "R9 byte after word");
    for (int i = 0; i < 16; i++) begin
      drive(i[0], i[1], 16'h1000 * i + 16'h0F0F, i[2], i[3], 16'hF0F0 - 16'h0101 * i,
            "R4 R6 R7 sweep");
    end
    drive(0, 0, 16'h0000, 0, 0, 16'h0000, "R9 final idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule